// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block runs on the master side of a three-wire SPI link and brings a target device into its serial programming mode. A `start` request makes it pull the target's active-low reset line low while it keeps the serial clock low and quiet. It then waits a settling time measured in system clock cycles. After that it clocks out the four-byte enable instruction, most significant bit first, and watches what the target returns during the third byte.

If the target returns the synchronisation byte in that slot, the link is in step. The block then raises `ready` and keeps the target in reset so that a higher layer can issue memory commands. If the target returns anything else, the instruction is still finished first. The block then releases reset for a short pulse of a set width and starts the whole attempt again. After a set number of failed attempts it gives up, raises `failed` and releases the target. Every outcome is also marked by a one-cycle `done` pulse.

While the target's data output may be floating, the block asks the pad logic for a pull-up on MISO. The byte shifter is a separate SPI mode-0 engine with a parameterised clock divider.

Top module: `isp_entry_seq`

## Requirements
- R1: `tgt_rst_n` is low from the cycle after an accepted `start` through every attempt, and it stays low while `ready` is high. It is high in the idle state and after a give-up.
- R2: `sck` is low whenever no byte transfer is running. It is low in idle, during the settling wait, during the reset pulse and while `ready` is high.
- R3: At least `SETTLE_CYC` system clock cycles pass between a falling edge of `tgt_rst_n` and the first rising edge of `sck` of that attempt.
- R4: Each attempt sends exactly four bytes, 0xAC, 0x53, 0x00 and 0x00 in that order, MSB first, in SPI mode 0. MOSI changes only while `sck` is low, MISO is sampled at the rising edge, and each `sck` phase lasts `SCK_HALF` cycles. All 32 clock pulses are sent even when the echo check has failed.
- R5: An attempt succeeds exactly when the byte captured from MISO during the third byte equals 0x53.
- R6: After a failed attempt with tries remaining, `tgt_rst_n` goes high for exactly `PULSE_CYC` cycles and then low again, and a new settle-and-send attempt follows.
- R7: After `MAX_TRIES` failed attempts the block stops. It raises `failed`, leaves `ready` low, releases `tgt_rst_n` and makes no further attempt.
- R8: `done` is a one-cycle pulse issued with the outcome, and exactly one of `ready` and `failed` is high while it is high. Both flags hold their value until the next accepted `start`.
- R9: `miso_pu_en` is high during the settling wait and the transfers of every attempt, and low in idle, during the reset pulse and while `ready` is high.
- R10: `start` is accepted only in the idle state or while `ready` is high. It is ignored during an entry sequence. A start accepted while `ready` is high begins with a reset pulse of `PULSE_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | Request to run the entry sequence |
| miso | input | 1 | Serial data from the target |
| tgt_rst_n | output | 1 | Active-low reset driven to the target |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso_pu_en | output | 1 | Enable for the pull-up on the MISO pad |
| done | output | 1 | One-cycle outcome strobe |
| ready | output | 1 | Target is in programming mode and synchronised |
| failed | output | 1 | Retry budget exhausted |

## Verification
The bench builds the block with `SCK_HALF`=2, `SETTLE_CYC`=40, `PULSE_CYC`=6 and `MAX_TRIES`=4. With these values one attempt takes under two hundred cycles, so the retry path, the give-up after four attempts and a restart from the synchronised state all fit in one short run. A behavioural target echoes the previous byte once it is in step and leaves MISO pulled high for a chosen number of attempts. The small pulse and settle values let the bench check the exact pulse width and the minimum settle gap against the requirement values.

// File: rtl/isp_entry_pkg.sv
package isp_entry_pkg;

   localparam int BYTE_W    = 8;
   localparam int CMD_BYTES = 4;
   localparam int IDX_W     = $clog2(CMD_BYTES);
   localparam int CHECK_IDX = 2;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_SETTLE,
      SEQ_XFER,
      SEQ_PULSE,
      SEQ_LINKED
   } seq_state_e;

endpackage

// File: rtl/isp_wait_timer.sv
module isp_wait_timer #(
   parameter int MAX_CYC = 1000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [$clog2(MAX_CYC+1)-1:0] len,
   output logic                       expired
);
   localparam int CW = $clog2(MAX_CYC+1);

   logic [CW-1:0] cnt;
   logic          run;

   assign expired = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= len - 1'b1;
         run <= 1'b1;
      end else if (expired) begin
         run <= 1'b0;
      end else if (run) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/isp_spi_byte.sv
module isp_spi_byte #(
   parameter int SCK_HALF = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       go,
   input  isp_entry_pkg::byte_t       tx,
   input  logic                       miso,
   output logic                       sck,
   output logic                       mosi,
   output logic                       done,
   output isp_entry_pkg::byte_t       rx
);
   import isp_entry_pkg::*;

   localparam int BW = $clog2(BYTE_W);

   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

   phase_e        ph;
   byte_t         sh;
   logic [BW-1:0] bits;
   logic          tick;

   generate
      if (SCK_HALF == 1) begin : g_nodiv
         assign tick = (ph != PH_IDLE);
      end else begin : g_div
         localparam int DW = $clog2(SCK_HALF);
         logic [DW-1:0] dcnt;
         assign tick = (ph != PH_IDLE) && (dcnt == DW'(SCK_HALF-1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           dcnt <= '0;
            else if (go || tick || ph == PH_IDLE) dcnt <= '0;
            else                                  dcnt <= dcnt + 1'b1;
         end
      end
   endgenerate

   assign mosi = sh[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         sh   <= '0;
         bits <= '0;
         sck  <= 1'b0;
         done <= 1'b0;
         rx   <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            sh   <= tx;
            bits <= '0;
            sck  <= 1'b0;
            ph   <= PH_LOW;
         end else begin
            case (ph)
               PH_LOW: if (tick) begin
                  sck <= 1'b1;
                  rx  <= {rx[BYTE_W-2:0], miso};
                  ph  <= PH_HIGH;
               end
               PH_HIGH: if (tick) begin
                  sck <= 1'b0;
                  if (bits == BW'(BYTE_W-1)) begin
                     ph   <= PH_IDLE;
                     done <= 1'b1;
                  end else begin
                     bits <= bits + 1'b1;
                     sh   <= {sh[BYTE_W-2:0], 1'b0};
                     ph   <= PH_LOW;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/isp_entry_seq.sv
module isp_entry_seq #(
   parameter int                   SCK_HALF   = 4,
   parameter int                   SETTLE_CYC = 1000000,
   parameter int                   PULSE_CYC  = 100,
   parameter int                   MAX_TRIES  = 32,
   parameter isp_entry_pkg::byte_t LEAD_BYTE  = 8'hAC,
   parameter isp_entry_pkg::byte_t SYNC_BYTE  = 8'h53,
   parameter isp_entry_pkg::byte_t FILL_BYTE  = 8'h00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic miso,
   output logic tgt_rst_n,
   output logic sck,
   output logic mosi,
   output logic miso_pu_en,
   output logic done,
   output logic ready,
   output logic failed
);
   import isp_entry_pkg::*;

   localparam int TMAX = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
   localparam int TW   = $clog2(TMAX+1);
   localparam int TRW  = $clog2(MAX_TRIES+1);

   generate
      if (SCK_HALF < 1)   begin : g_bad_half   $error("SCK_HALF must be at least 1");   end
      if (SETTLE_CYC < 1) begin : g_bad_settle $error("SETTLE_CYC must be at least 1"); end
      if (PULSE_CYC < 1)  begin : g_bad_pulse  $error("PULSE_CYC must be at least 1");  end
      if (MAX_TRIES < 1)  begin : g_bad_tries  $error("MAX_TRIES must be at least 1");  end
   endgenerate

   function automatic byte_t seq_byte(input logic [IDX_W-1:0] i);
      case (i)
         IDX_W'(0): return LEAD_BYTE;
         IDX_W'(1): return SYNC_BYTE;
         default:   return FILL_BYTE;
      endcase
   endfunction

   seq_state_e       state;
   logic [IDX_W-1:0] idx, nxt_idx;
   logic [TRW-1:0]   tries;
   logic             sync_ok;
   logic             t_load, t_exp, go, x_done;
   logic [TW-1:0]    t_len;
   byte_t            rx_byte;
   logic             last_idx, last_try;

   assign last_idx = (idx == IDX_W'(CMD_BYTES-1));
   assign last_try = (tries == TRW'(MAX_TRIES-1));

   always_comb begin
      t_load  = 1'b0;
      t_len   = TW'(SETTLE_CYC);
      go      = 1'b0;
      nxt_idx = idx;
      case (state)
         SEQ_IDLE:   if (start) t_load = 1'b1;
         SEQ_LINKED: if (start) begin
            t_load = 1'b1;
            t_len  = TW'(PULSE_CYC);
         end
         SEQ_SETTLE: if (t_exp) begin
            go      = 1'b1;
            nxt_idx = '0;
         end
         SEQ_XFER: if (x_done) begin
            if (!last_idx) begin
               go      = 1'b1;
               nxt_idx = idx + 1'b1;
            end else if (!sync_ok && !last_try) begin
               t_load = 1'b1;
               t_len  = TW'(PULSE_CYC);
            end
         end
         SEQ_PULSE: if (t_exp) t_load = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         idx     <= '0;
         tries   <= '0;
         sync_ok <= 1'b0;
         ready   <= 1'b0;
         failed  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) idx <= nxt_idx;
         case (state)
            SEQ_IDLE, SEQ_LINKED: if (start) begin
               state  <= (state == SEQ_IDLE) ? SEQ_SETTLE : SEQ_PULSE;
               tries  <= '0;
               ready  <= 1'b0;
               failed <= 1'b0;
            end
            SEQ_SETTLE: if (t_exp) begin
               state   <= SEQ_XFER;
               sync_ok <= 1'b0;
            end
            SEQ_XFER: if (x_done) begin
               if (idx == IDX_W'(CHECK_IDX)) sync_ok <= (rx_byte == SYNC_BYTE);
               if (last_idx) begin
                  if (sync_ok) begin
                     state <= SEQ_LINKED;
                     ready <= 1'b1;
                     done  <= 1'b1;
                  end else if (last_try) begin
                     state  <= SEQ_IDLE;
                     failed <= 1'b1;
                     done   <= 1'b1;
                  end else begin
                     state <= SEQ_PULSE;
                     tries <= tries + 1'b1;
                  end
               end
            end
            SEQ_PULSE: if (t_exp) state <= SEQ_SETTLE;
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign tgt_rst_n  = !(state == SEQ_SETTLE || state == SEQ_XFER || state == SEQ_LINKED);
   assign miso_pu_en = (state == SEQ_SETTLE || state == SEQ_XFER);

   isp_wait_timer #(.MAX_CYC(TMAX)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .len     (t_len),
      .expired (t_exp)
   );

   isp_spi_byte #(.SCK_HALF(SCK_HALF)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .tx   (seq_byte(nxt_idx)),
      .miso (miso),
      .sck  (sck),
      .mosi (mosi),
      .done (x_done),
      .rx   (rx_byte)
   );
endmodule

// File: rtl/isp_entry_seq_chk.sv
module isp_entry_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic tgt_rst_n,
   input logic sck,
   input logic miso_pu_en,
   input logic done,
   input logic ready,
   input logic failed
);
   // R1
   linked_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !tgt_rst_n);

   // R2
   released_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rst_n || ready) |-> !sck);

   // R2
   sck_rise_in_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> miso_pu_en);

   // R8
   done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ready ^ failed));

   // R8
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && failed));

   // R9
   pullup_in_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt_rst_n && !ready) |-> miso_pu_en);

   // R9
   pullup_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miso_pu_en |-> !tgt_rst_n);
endmodule

bind isp_entry_seq isp_entry_seq_chk u_chk (.*);

// File: tb/tb_isp_entry_seq.sv
module tb_isp_entry_seq;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;
   localparam int SETTLE     = 40;
   localparam int PULSE      = 6;
   localparam int TRIES      = 4;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic miso;
   logic tgt_rst_n, sck, mosi, miso_pu_en, done, ready, failed;

   always #(CLK_PERIOD/2) clk = ~clk;

   isp_entry_seq #(
      .SCK_HALF(HALF), .SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE), .MAX_TRIES(TRIES)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
      .tgt_rst_n(tgt_rst_n), .sck(sck), .mosi(mosi), .miso_pu_en(miso_pu_en),
      .done(done), .ready(ready), .failed(failed)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural target
   int         bad_n = 0;
   int         attempt_n = 0;
   int         bitc = 0;
   int         nbytes = 0;
   int         rises = 0;
   bit         in_sync = 0;
   bit         in_case = 0;
   logic [7:0] prev = 8'h00;
   logic [7:0] cur = 8'h00;
   logic [7:0] got [4];
   int         settle_cnt = 0;
   bit         rise_seen = 0;

   assign miso = (!tgt_rst_n && in_sync) ? prev[3'(7 - bitc)] : 1'b1;

   always @(negedge tgt_rst_n) begin
      // R4: every finished attempt clocked all 32 pulses
      if (in_case && attempt_n > 0) chk(rises == 32, "R4 pulses per failed attempt", rises, 32);
      attempt_n++;
      in_sync    = (attempt_n > bad_n);
      bitc       = 0;
      prev       = 8'h00;
      cur        = 8'h00;
      nbytes     = 0;
      rises      = 0;
      settle_cnt = 0;
      rise_seen  = 0;
   end

   always @(posedge sck) begin
      if (!tgt_rst_n) begin
         cur = {cur[6:0], mosi};
         bitc++;
         rises++;
         if (bitc == 8) begin
            if (nbytes < 4) got[nbytes] = cur;
            nbytes++;
            prev = cur;
            bitc = 0;
         end
      end
   end

   // scoreboard
   typedef struct {
      bit    ok;
      int    tries;
      string tag;
   } exp_t;
   exp_t q[$];

   int   cyc = 0;
   int   done_seen = 0;
   bit   wd_hit = 0;
   logic prev_rst = 1'b1;
   bit   hi_active = 0;
   int   hi_cnt = 0;

   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !wd_hit) begin
         wd_hit = 1;
         chk(0, "watchdog", cyc, WATCHDOG);
      end
      if (!tgt_rst_n && miso_pu_en && !sck && !rise_seen) settle_cnt++;
      if (sck && !rise_seen) begin
         rise_seen = 1;
         // R3
         chk(settle_cnt >= SETTLE, "R3 settle before first clock", settle_cnt, SETTLE);
         // R9
         chk(miso_pu_en == 1'b1, "R9 pull-up during transfer", miso_pu_en, 1);
      end
      if (in_case && tgt_rst_n && !prev_rst) begin
         hi_active = 1;
         hi_cnt    = 0;
      end
      if (hi_active && tgt_rst_n) hi_cnt++;
      if (hi_active && !tgt_rst_n && prev_rst) begin
         // R6 / R10 reset pulse width
         chk(hi_cnt == PULSE, "R6 reset pulse width", hi_cnt, PULSE);
         hi_active = 0;
      end
      if (done) begin
         hi_active = 0;
         if (q.size() == 0) begin
            chk(0, "R8 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            // R5 / R7 / R8 outcome
            chk(ready == e.ok && failed == !e.ok, {e.tag, " outcome flags"}, {ready, failed}, {e.ok, !e.ok});
            chk(attempt_n == e.tries, {e.tag, " attempt count"}, attempt_n, e.tries);
            chk(rises == 32, "R4 pulses in final attempt", rises, 32);
            if (e.ok) begin
               // R4 byte order
               chk(got[0] == 8'hAC, "R4 byte 0", got[0], 8'hAC);
               chk(got[1] == 8'h53, "R4 byte 1", got[1], 8'h53);
               chk(got[2] == 8'h00 && got[3] == 8'h00, "R4 bytes 2-3", {got[2], got[3]}, 0);
               // R1
               chk(tgt_rst_n == 1'b0, "R1 reset held when ready", tgt_rst_n, 0);
            end else begin
               // R7
               chk(tgt_rst_n == 1'b1, "R7 reset released on give-up", tgt_rst_n, 1);
            end
         end
         done_seen++;
      end
      prev_rst = tgt_rst_n;
   end

   task automatic run_case(input int bad, input bit ok, input int tries,
                           input string tag, input bit poke);
      int seen;
      exp_t e;
      seen = done_seen;
      @(negedge clk);
      bad_n     = bad;
      attempt_n = 0;
      in_case   = 1;
      e.ok = ok; e.tries = tries; e.tag = tag;
      q.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (60) @(negedge clk);
         // R10: start during the sequence has no effect
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (done_seen == seen && !wd_hit) @(negedge clk);
      in_case = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: R1 R2 R8 R9
      chk(tgt_rst_n == 1'b1, "R1 idle reset released", tgt_rst_n, 1);
      chk(sck == 1'b0, "R2 idle sck low", sck, 0);
      chk(!ready && !failed && !done, "R8 idle flags", {ready, failed, done}, 0);
      chk(miso_pu_en == 1'b0, "R9 idle pull-up off", miso_pu_en, 0);

      run_case(0, 1'b1, 1, "R5 first-try", 1'b0);
      repeat (50) @(negedge clk);
      // R2 / R1 / R9 while ready
      chk(sck == 1'b0 && tgt_rst_n == 1'b0, "R2 linked quiet", {sck, tgt_rst_n}, 0);
      chk(ready == 1'b1 && miso_pu_en == 1'b0, "R9 linked pull-up off", {ready, miso_pu_en}, 2);

      run_case(2, 1'b1, 3, "R10 restart with R6 retries", 1'b1);
      run_case(10, 1'b0, TRIES, "R7 give-up", 1'b0);
      repeat (100) @(negedge clk);
      // R7: no further attempt, flag held
      chk(failed == 1'b1 && tgt_rst_n == 1'b1 && sck == 1'b0, "R7 stays idle",
          {failed, tgt_rst_n, sck}, 6);
      chk(attempt_n == TRIES, "R7 no extra attempt", attempt_n, TRIES);

      run_case(0, 1'b1, 1, "R8 recover after fail", 1'b0);
      chk(q.size() == 0, "R8 all outcomes seen", q.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule